// File: doc/BRIEF.md
# Channel Status Integrity and Change Monitor

This block sits behind a digital audio receiver's channel status assembler. Each time a status byte of either channel is complete, the assembler presents it with its position in the 24-byte block and a channel tag. The monitor keeps a running CRC per channel across bytes 0 to 22 and compares the result with byte 23. It also remembers the opening four bytes of the last complete block of each channel and flags any difference in the next complete block.

The results are gathered in an 8-bit status register. A host polls this register: bit 7 is the CRC error flag of channel 0 and bit 6 is the CRC error flag of channel 1. Bit 5 is the shared change flag. Every flag stays set until the host reads the register, and the read clears it. Software can therefore poll only the change bit and skip comparing the header bytes itself.

Top module: `cs_status_monitor`

## Requirements
- R1: The CRC of a channel's block uses the polynomial x^8+x^4+x^3+x^2+1 (0x1D). The register starts at 0xFF, and bytes 0..22 enter least significant bit first: for each bit, feedback = crc[7] XOR data bit, crc shifts left by one, and 0x1D is XORed in when feedback is 1. If the final value differs from byte 23, the channel's error bit is set on the clock edge that samples byte 23.
- R2: When byte 23 equals the computed CRC, no error bit is set.
- R3: Channel tag 0 drives status bit 7 and channel tag 1 drives status bit 6. The CRC state of one channel is not affected by bytes of the other, so the two channels' bytes may be interleaved freely.
- R4: Status bit 5 is set on the edge that samples byte 23 of a complete block when that block's bytes 0..3, for either channel, differ from the same channel's bytes 0..3 of its previous complete block.
- R5: The first complete block of a channel after reset never sets bit 5. Differences confined to bytes 4..23 never set bit 5.
- R6: Bits 7, 6 and 5 are sticky. They clear on the clock edge where the read strobe is high. An event in that same cycle leaves its bit set.
- R7: A block is complete only when its bytes arrive with indices 0,1,...,23 in order for that channel. Index 0 always begins a new block. A block that is abandoned or out of order raises no CRC error and leaves the stored bytes 0..3 unchanged.
- R8: After reset the status register reads 0x00. Bits 4..0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld_i | input | 1 | A completed status byte is presented this cycle |
| byte_chan_i | input | 1 | Channel tag of the byte (0 or 1) |
| byte_idx_i | input | 5 | Position of the byte in its block, 0..23 |
| byte_data_i | input | 8 | Status byte value |
| rd_stb_i | input | 1 | Host read of the status register; clears sticky bits |
| status_o | output | 8 | Status register: bit 7 CRC error ch0, bit 6 CRC error ch1, bit 5 change |

## Verification
The bench interleaves bytes of both channels and randomly cuts blocks short. A design that shared CRC state between channels, or that treated a truncated block as complete, would then report false errors or false changes. Directed cases cover the first block after reset, which must stay quiet. They also cover a block whose header repeats but whose tail changes, where a design that compared too many bytes would set the change bit. A CRC error that lands in the same cycle as a read must survive the clear. A design that gave the clear priority would lose it. A skipped index followed by a wrong byte 23 must raise nothing.

// File: rtl/cs_mon_pkg.sv
package cs_mon_pkg;

   localparam int STAT_W     = 8;
   localparam int ST_ERR_CH0 = 7;
   localparam int ST_ERR_CH1 = 6;
   localparam int ST_CHG     = 5;

   function automatic logic [7:0] crc8_step_lsb(input logic [7:0] crc,
                                                input logic [7:0] din,
                                                input logic [7:0] poly);
      logic [7:0] r;
      logic       fb;
      r = crc;
      for (int i = 0; i < 8; i++) begin
         fb = r[7] ^ din[i];
         r  = {r[6:0], 1'b0};
         if (fb) r = r ^ poly;
      end
      return r;
   endfunction

   function automatic logic [7:0] crc8_step_msb(input logic [7:0] crc,
                                                input logic [7:0] din,
                                                input logic [7:0] poly);
      logic [7:0] r;
      logic       fb;
      r = crc;
      for (int i = 7; i >= 0; i--) begin
         fb = r[7] ^ din[i];
         r  = {r[6:0], 1'b0};
         if (fb) r = r ^ poly;
      end
      return r;
   endfunction

endpackage

// File: rtl/cs_blk_crc.sv
module cs_blk_crc
   import cs_mon_pkg::*;
#(
   parameter int         BLOCK_BYTES = 24,
   parameter int         HEAD_BYTES  = 4,
   parameter int         IDX_W       = 5,
   parameter logic [7:0] CRC_POLY    = 8'h1D,
   parameter logic [7:0] CRC_INIT    = 8'hFF,
   parameter bit         LSB_FIRST   = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sel_i,
   input  logic [IDX_W-1:0]        idx_i,
   input  logic [7:0]              data_i,
   output logic                    done_o,
   output logic                    bad_o,
   output logic [HEAD_BYTES*8-1:0] head_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_BYTES - 1);
   localparam logic [IDX_W-1:0] ZERO_IDX = '0;

   logic [7:0]              crc_q;
   logic [7:0]              crc_seed;
   logic [7:0]              crc_nx;
   logic [IDX_W-1:0]        exp_q;
   logic                    live_q;
   logic [HEAD_BYTES*8-1:0] head_q;
   logic                    starting;
   logic                    in_order;

   assign starting = (idx_i == ZERO_IDX);
   assign in_order = live_q && (idx_i == exp_q) && !starting;
   assign crc_seed = starting ? CRC_INIT : crc_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign crc_nx = crc8_step_lsb(crc_seed, data_i, CRC_POLY);
      end else begin : g_msb
         assign crc_nx = crc8_step_msb(crc_seed, data_i, CRC_POLY);
      end
   endgenerate

   assign done_o = sel_i && in_order && (idx_i == LAST_IDX);
   assign bad_o  = (crc_q != data_i);
   assign head_o = head_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= 1'b0;
         exp_q  <= '0;
         crc_q  <= CRC_INIT;
      end else if (sel_i) begin
         if (starting) begin
            live_q <= 1'b1;
            exp_q  <= IDX_W'(1);
            crc_q  <= crc_nx;
         end else if (in_order && (idx_i != LAST_IDX)) begin
            exp_q <= exp_q + 1'b1;
            crc_q <= crc_nx;
         end else begin
            live_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
      end else if (sel_i && (starting || in_order)) begin
         for (int k = 0; k < HEAD_BYTES; k++) begin
            if (idx_i == IDX_W'(k)) head_q[k*8 +: 8] <= data_i;
         end
      end
   end

   assert_exp_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> (exp_q <= LAST_IDX));

   assert_broken_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && !live_q && !starting) |=> !live_q);

endmodule

// File: rtl/cs_head_cmp.sv
module cs_head_cmp #(
   parameter int HEAD_BITS = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 done_i,
   input  logic [HEAD_BITS-1:0] head_i,
   output logic                 chg_o
);

   logic [HEAD_BITS-1:0] ref_q;
   logic                 ref_vld_q;

   assign chg_o = done_i && ref_vld_q && (head_i != ref_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_q     <= '0;
         ref_vld_q <= 1'b0;
      end else if (done_i) begin
         ref_q     <= head_i;
         ref_vld_q <= 1'b1;
      end
   end

   assert_ref_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done_i |=> $stable(ref_q));

   assert_first_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_vld_q) |-> !$past(chg_o));

endmodule

// File: rtl/cs_status_monitor.sv
module cs_status_monitor
   import cs_mon_pkg::*;
#(
   parameter int         BLOCK_BYTES = 24,
   parameter int         HEAD_BYTES  = 4,
   parameter logic [7:0] CRC_POLY    = 8'h1D,
   parameter logic [7:0] CRC_INIT    = 8'hFF,
   parameter bit         LSB_FIRST   = 1'b1,
   localparam int        IDX_W       = $clog2(BLOCK_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_vld_i,
   input  logic             byte_chan_i,
   input  logic [IDX_W-1:0] byte_idx_i,
   input  logic [7:0]       byte_data_i,
   input  logic             rd_stb_i,
   output logic [7:0]       status_o
);

   localparam int NUM_CH    = 2;
   localparam int HEAD_BITS = HEAD_BYTES * 8;

   generate
      if (BLOCK_BYTES < HEAD_BYTES + 2) begin : g_bad_block
         $error("block must hold the header bytes plus payload and CRC");
      end
      if (HEAD_BYTES < 1) begin : g_bad_head
         $error("at least one header byte is compared");
      end
   endgenerate

   logic [NUM_CH-1:0] done_w;
   logic [NUM_CH-1:0] bad_w;
   logic [NUM_CH-1:0] chg_w;
   logic [STAT_W-1:0] set_vec;
   logic [STAT_W-1:0] status_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic                 sel;
      logic [HEAD_BITS-1:0] head;

      assign sel = byte_vld_i && (byte_chan_i == c[0]);

      cs_blk_crc #(
         .BLOCK_BYTES(BLOCK_BYTES),
         .HEAD_BYTES (HEAD_BYTES),
         .IDX_W      (IDX_W),
         .CRC_POLY   (CRC_POLY),
         .CRC_INIT   (CRC_INIT),
         .LSB_FIRST  (LSB_FIRST)
      ) crc_i (
         .clk   (clk),
         .rst_n (rst_n),
         .sel_i (sel),
         .idx_i (byte_idx_i),
         .data_i(byte_data_i),
         .done_o(done_w[c]),
         .bad_o (bad_w[c]),
         .head_o(head)
      );

      cs_head_cmp #(
         .HEAD_BITS(HEAD_BITS)
      ) cmp_i (
         .clk   (clk),
         .rst_n (rst_n),
         .done_i(done_w[c]),
         .head_i(head),
         .chg_o (chg_w[c])
      );
   end

   always_comb begin
      set_vec             = '0;
      set_vec[ST_ERR_CH0] = done_w[0] && bad_w[0];
      set_vec[ST_ERR_CH1] = done_w[1] && bad_w[1];
      set_vec[ST_CHG]     = |chg_w;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (rd_stb_i ? '0 : status_q) | set_vec;
   end

   assign status_o = status_q;

   assert_err0_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done_w[0] && bad_w[0]) |=> status_q[ST_ERR_CH0]);

   assert_err1_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_w[1] && bad_w[1]) |=> status_q[ST_ERR_CH1]);

   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[ST_CHG] && !rd_stb_i) |=> status_q[ST_CHG]);

   assert_rd_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && (done_w == '0)) |=> (status_q == '0));

   assert_chg_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q[ST_CHG]) |-> $past(|done_w));

   assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      status_q[4:0] == 5'd0);

endmodule

// File: tb/cs_status_monitor_tb.sv
module cs_status_monitor_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       byte_vld;
   logic       byte_chan;
   logic [4:0] byte_idx;
   logic [7:0] byte_data;
   logic       rd_stb;
   logic [7:0] status;

   int checks = 0;
   int errors = 0;
   bit done_run = 1'b0;

   logic [7:0]  blk [2][24];
   logic [31:0] prev_head [2];
   bit          prev_vld  [2];
   logic [7:0]  exp_st;

   always #2 clk = ~clk;

   cs_status_monitor dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_vld_i (byte_vld),
      .byte_chan_i(byte_chan),
      .byte_idx_i (byte_idx),
      .byte_data_i(byte_data),
      .rd_stb_i   (rd_stb),
      .status_o   (status)
   );

   function automatic logic [7:0] ref_crc(input int ch);
      logic [7:0] c = 8'hFF;
      for (int n = 0; n < 23; n++) begin
         for (int b = 0; b < 8; b++) begin
            if (c[7] != blk[ch][n][b]) c = (c << 1) ^ 8'h1D;
            else                       c = c << 1;
         end
      end
      return c;
   endfunction

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: status actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic build(input int ch, input logic [31:0] head, input bit corrupt);
      for (int n = 0; n < 4; n++) blk[ch][n] = head[n*8 +: 8];
      for (int n = 4; n < 23; n++) blk[ch][n] = 8'($urandom);
      blk[ch][23] = ref_crc(ch);
      if (corrupt) blk[ch][23] = blk[ch][23] ^ (8'h01 << ($urandom % 8));
   endtask

   task automatic put(input int ch, input int idx, input logic [7:0] d);
      @(negedge clk);
      byte_vld  = 1'b1;
      byte_chan = ch[0];
      byte_idx  = 5'(idx);
      byte_data = d;
   endtask

   task automatic idle();
      @(negedge clk);
      byte_vld = 1'b0;
   endtask

   task automatic model_done(input int ch, input bit corrupt);
      logic [31:0] h = {blk[ch][3], blk[ch][2], blk[ch][1], blk[ch][0]};
      if (corrupt) exp_st[ch == 0 ? 7 : 6] = 1'b1;
      if (prev_vld[ch] && prev_head[ch] != h) exp_st[5] = 1'b1;
      prev_head[ch] = h;
      prev_vld[ch]  = 1'b1;
   endtask

   task automatic send(input int ch, input bit corrupt);
      for (int n = 0; n < 24; n++) put(ch, n, blk[ch][n]);
      idle();
      model_done(ch, corrupt);
   endtask

   task automatic read_chk(input string tag);
      @(negedge clk);
      byte_vld = 1'b0;
      chk(status, exp_st, tag);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      exp_st = 8'h00;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_run) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] h0, hsel;
      int          lenA, lenB;
      bit          cA, cB;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; byte_vld = 1'b0; byte_chan = 1'b0; byte_idx = '0;
      byte_data = '0; rd_stb = 1'b0; exp_st = '0;
      prev_vld[0] = 0; prev_vld[1] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(status, 8'h00, "R8 reset value");

      h0 = 32'h0402_0100;
      build(0, h0, 1'b0); send(0, 1'b0);
      read_chk("R2 R5 first good block ch0");

      build(0, h0, 1'b1); send(0, 1'b1);
      read_chk("R1 bad CRC ch0 sets bit7");
      read_chk("R6 read clears");

      build(1, 32'h1111_2222, 1'b1); send(1, 1'b1);
      read_chk("R3 bad CRC ch1 sets bit6");

      build(0, 32'h0402_0101, 1'b0); send(0, 1'b0);
      read_chk("R4 header change ch0");

      build(0, 32'h0402_0101, 1'b0); blk[0][10] = blk[0][10] ^ 8'h5A;
      blk[0][23] = ref_crc(0); send(0, 1'b0);
      read_chk("R5 tail change only");

      build(1, 32'h1111_2223, 1'b0); send(1, 1'b0);
      read_chk("R4 header change ch1");

      // R7: abandoned block with a new header, then a full block with the old one
      build(0, 32'hAAAA_5555, 1'b1);
      for (int n = 0; n < 16; n++) put(0, n, blk[0][n]);
      build(0, 32'h0402_0101, 1'b0); send(0, 1'b0);
      read_chk("R7 abandoned block ignored");

      // R7: skipped index then a wrong byte 23
      build(0, 32'hAAAA_5555, 1'b1);
      for (int n = 0; n < 24; n++) if (n != 6) put(0, n, blk[0][n]);
      idle();
      read_chk("R7 out-of-order block ignored");

      // R6: sticky across idle cycles, event in read cycle wins
      build(0, 32'h0402_0101, 1'b1); send(0, 1'b1);
      repeat (5) idle();
      chk(status, 8'h80, "R6 sticky while idle");
      build(1, 32'h1111_2223, 1'b1);
      for (int n = 0; n < 23; n++) put(1, n, blk[1][n]);
      put(1, 23, blk[1][23]);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0; byte_vld = 1'b0;
      chk(status, 8'h40, "R6 event beats same-cycle clear");
      prev_head[1] = 32'h1111_2223;
      exp_st = 8'h40;
      read_chk("R6 cleanup read");

      // Random interleaved traffic on both channels
      for (int it = 0; it < 80; it++) begin
         for (int ch = 0; ch < 2; ch++) begin
            case ($urandom % 4)
               0: hsel = 32'h0000_0000;
               1: hsel = 32'h1234_5678;
               2: hsel = prev_head[ch];
               default: hsel = prev_head[ch] ^ (32'h1 << ($urandom % 32));
            endcase
            build(ch, hsel, ($urandom % 3) == 0);
            blk[ch][23] = (($urandom % 3) == 0) ? blk[ch][23] : ref_crc(ch);
         end
         cA = (blk[0][23] != ref_crc(0));
         cB = (blk[1][23] != ref_crc(1));
         lenA = (($urandom % 5) == 0) ? 1 + ($urandom % 23) : 24;
         lenB = (($urandom % 5) == 0) ? 1 + ($urandom % 23) : 24;
         for (int n = 0; n < 24; n++) begin
            if (n < lenA) put(0, n, blk[0][n]);
            if (n < lenB) put(1, n, blk[1][n]);
            if (($urandom % 4) == 0) idle();
         end
         idle();
         if (lenA == 24) model_done(0, cA);
         if (lenB == 24) model_done(1, cB);
         if ((it % 2) == 1 || exp_st != 0) read_chk("R1 R3 R4 R7 random interleave");
      end

      read_chk("R8 final");
      done_run = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule